// File: doc/BRIEF.md
# Bus Command Addressing Sequencer

This block sits on the controller side of an instrument bus. It drives the 8-bit register port of an attached bus-interface chip, which handles the handshake wires itself. The port has a 3-bit register select, an active-low write strobe and an active-low read strobe. From a single host request it plays out the full register sequence that takes control of the bus, addresses a device and sends a universal or addressed command. It then returns the bus to standby.

The host presents an opcode and a 5-bit device address together with a one-cycle `start` pulse. The block answers with `busy` while it runs. It ends with a one-cycle `done`, and `error` is raised if the chip never reports that a command byte left. Every command byte written to the output register is followed by polling of status register 0 until its byte-out bit is set. After the final standby command, a settle interval runs before `done`. Strobe width, poll interval, settle time and poll budget are parameters counted in clock cycles.

Top module: `bus_cmd_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0, `rd_n` and `wr_n` are 1, and `dout_oe` is 0.
- R2: A `start` pulse is accepted only while idle and only with opcode 0 (clear all), 1 (selected clear), 2 (go-to-local), 3 (trigger) or 4 (remote enable). `busy` is 1 in the cycle after acceptance. A `start` while busy, or with opcode 5 to 7, causes no register access and does not change the running sequence.
- R3: Opcode 0 writes, in order: aux 0x0C, command 0x3F, command 0x5F, command 0x14, aux 0x0B.
- R4: Opcodes 1, 2 and 3 write, in order: aux 0x0C, command 0x3F, aux 0x8A, command 0x20+address, then the command byte (0x04, 0x01 or 0x08 respectively), then aux 0x0B.
- R5: Opcode 4 writes, in order: aux 0x90, aux 0x0C, command 0x3F, aux 0x8A, command 0x20+address, aux 0x0B.
- R6: Auxiliary writes use register select 3, command bytes use register select 7, and every read uses register select 0.
- R7: After each command byte, the first status read starts POLL_GAP cycles after the write strobe ends. Reads repeat, POLL_GAP cycles apart, until a read returns bit 4 (mask 0x10) set. No write occurs while polling, and other status bits are ignored.
- R8: Every write and read strobe is low for exactly STROBE_W cycles, and the select and data stay stable while the write strobe is low.
- R9: `done` rises exactly SETTLE_CYC cycles after the standby write strobe ends. It lasts one cycle, and `busy` is 0 while it is high.
- R10: If POLL_LIMIT consecutive reads after a command byte return bit 4 clear, the sequence stops with no further writes and `done` pulses with `error` = 1. `error` stays 1 until the next accepted start clears it.
- R11: `dout_oe` is 1 exactly while `wr_n` is 0, and `rd_n` and `wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| opcode | input | 3 | Sequence selector (0 to 4) |
| dev_addr | input | 5 | Target device address |
| din | input | 8 | Read data from the chip register port |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Byte-out poll timed out in the last sequence |
| reg_sel | output | 3 | Chip register select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| dout | output | 8 | Write data to the chip register port |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
Each opcode is run with a different number of "not yet" status replies before byte-out appears: zero, one, two and three. This separates a design that polls exactly until the flag from one that reads a fixed count or skips polling. The not-ready reply sets every bit except bit 4, and the idle bus reads back all ones, so sampling the wrong bit or sampling outside the read strobe shows up as a wrong order or a wrong read count. Addresses 0, 5, 12, 3 and 31 exercise the listen-address sum at its ends. A never-ready chip distinguishes a correct timeout from a hang or from extra writes. A start with a reserved opcode and a start during a running sequence show whether stray requests leak onto the port.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    OP_CLEAR_ALL = 3'd0,
    OP_SEL_CLEAR = 3'd1,
    OP_TO_LOCAL  = 3'd2,
    OP_TRIGGER   = 3'd3,
    OP_REMOTE    = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    K_AUX      = 2'd0,
    K_CMD      = 2'd1,
    K_AUX_LAST = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] val;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WRITE, ST_GAP, ST_READ, ST_SETTLE, ST_DONE
  } state_e;

  // chip register selects
  localparam logic [2:0] SEL_STATUS = 3'd0;
  localparam logic [2:0] SEL_AUX    = 3'd3;
  localparam logic [2:0] SEL_OUT    = 3'd7;

  // auxiliary command codes
  localparam logic [7:0] AUX_TAKE_CTRL = 8'h0C;
  localparam logic [7:0] AUX_STANDBY   = 8'h0B;
  localparam logic [7:0] AUX_TALK_ONLY = 8'h8A;
  localparam logic [7:0] AUX_REMOTE_ON = 8'h90;

  // bus command bytes
  localparam logic [7:0] BYTE_UNLISTEN  = 8'h3F;
  localparam logic [7:0] BYTE_UNTALK    = 8'h5F;
  localparam logic [7:0] BYTE_DEV_CLEAR = 8'h14;
  localparam logic [7:0] BYTE_SEL_CLEAR = 8'h04;
  localparam logic [7:0] BYTE_TO_LOCAL  = 8'h01;
  localparam logic [7:0] BYTE_TRIGGER   = 8'h08;
  localparam logic [7:0] LISTEN_BASE    = 8'h20;

  localparam logic [7:0] BYTE_OUT_MASK  = 8'h10;

  function automatic logic op_valid(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bcs_step_rom.sv
module bcs_step_rom
  import bcs_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [4:0]        addr,
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);

  logic [7:0] listen_byte;
  logic [7:0] cmd_byte;

  assign listen_byte = LISTEN_BASE + {3'b000, addr};

  always_comb begin
    case (op)
      OP_SEL_CLEAR: cmd_byte = BYTE_SEL_CLEAR;
      OP_TO_LOCAL:  cmd_byte = BYTE_TO_LOCAL;
      default:      cmd_byte = BYTE_TRIGGER;
    endcase
  end

  // shared addressing prefix: take control, unlisten, talk-only, listen address
  function automatic step_t addr_step(input logic [STEP_W-1:0] k, input logic [7:0] lb);
    step_t s;
    case (k)
      3'd0:    s = '{kind: K_AUX, val: AUX_TAKE_CTRL};
      3'd1:    s = '{kind: K_CMD, val: BYTE_UNLISTEN};
      3'd2:    s = '{kind: K_AUX, val: AUX_TALK_ONLY};
      default: s = '{kind: K_CMD, val: lb};
    endcase
    return s;
  endfunction

  always_comb begin
    step = '{kind: K_AUX_LAST, val: AUX_STANDBY};
    case (op)
      OP_CLEAR_ALL: begin
        case (idx)
          3'd0: step = '{kind: K_AUX, val: AUX_TAKE_CTRL};
          3'd1: step = '{kind: K_CMD, val: BYTE_UNLISTEN};
          3'd2: step = '{kind: K_CMD, val: BYTE_UNTALK};
          3'd3: step = '{kind: K_CMD, val: BYTE_DEV_CLEAR};
          default: ;
        endcase
      end
      OP_REMOTE: begin
        if (idx == 3'd0)
          step = '{kind: K_AUX, val: AUX_REMOTE_ON};
        else if (idx <= 3'd4)
          step = addr_step(idx - 3'd1, listen_byte);
      end
      default: begin
        if (idx <= 3'd3)
          step = addr_step(idx, listen_byte);
        else if (idx == 3'd4)
          step = '{kind: K_CMD, val: cmd_byte};
      end
    endcase
  end

endmodule

// File: rtl/bcs_down_timer.sv
module bcs_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/bus_cmd_sequencer.sv
module bus_cmd_sequencer
  import bcs_pkg::*;
#(
  parameter int STROBE_W   = 4,
  parameter int POLL_GAP   = 6,
  parameter int SETTLE_CYC = 200,
  parameter int POLL_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] opcode,
  input  logic [4:0] dev_addr,
  input  logic [7:0] din,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [2:0] reg_sel,
  output logic       rd_n,
  output logic       wr_n,
  output logic [7:0] dout,
  output logic       dout_oe
);

  localparam int TMR_MAX = max3(STROBE_W, POLL_GAP, SETTLE_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PC_W    = $clog2(POLL_LIMIT + 1);
  localparam logic [TMR_W-1:0] T_STROBE = TMR_W'(STROBE_W - 1);
  localparam logic [TMR_W-1:0] T_GAP    = TMR_W'(POLL_GAP - 1);
  localparam logic [TMR_W-1:0] T_SETTLE = TMR_W'(SETTLE_CYC - 1);
  localparam logic [PC_W-1:0]  P_LIMIT  = PC_W'(POLL_LIMIT - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [2:0]        op_q, op_d;
  logic [4:0]        addr_q, addr_d;
  logic [7:0]        dout_q, dout_d;
  logic [2:0]        sel_q, sel_d;
  logic              wr_n_q, wr_n_d;
  logic              rd_n_q, rd_n_d;
  logic              err_q, err_d;

  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              pc_load, pc_dec, pc_zero;
  step_t             cur;

  bcs_step_rom u_rom (
    .op   (op_q),
    .addr (addr_q),
    .idx  (step_q),
    .step (cur)
  );

  bcs_down_timer #(.W(TMR_W)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (1'b1),
    .zero     (tmr_zero)
  );

  bcs_down_timer #(.W(PC_W)) u_poll_budget (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (pc_load),
    .load_val (P_LIMIT),
    .dec      (pc_dec),
    .zero     (pc_zero)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    op_d     = op_q;
    addr_d   = addr_q;
    dout_d   = dout_q;
    sel_d    = sel_q;
    wr_n_d   = wr_n_q;
    rd_n_d   = rd_n_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    pc_load  = 1'b0;
    pc_dec   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start && op_valid(opcode)) begin
          op_d    = opcode;
          addr_d  = dev_addr;
          step_d  = '0;
          err_d   = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        sel_d    = (cur.kind == K_CMD) ? SEL_OUT : SEL_AUX;
        dout_d   = cur.val;
        wr_n_d   = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = T_STROBE;
        state_d  = ST_WRITE;
      end
      ST_WRITE: begin
        if (tmr_zero) begin
          wr_n_d = 1'b1;
          if (cur.kind == K_CMD) begin
            pc_load  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = T_GAP;
            state_d  = ST_GAP;
          end else if (cur.kind == K_AUX_LAST) begin
            tmr_load = 1'b1;
            tmr_val  = T_SETTLE;
            state_d  = ST_SETTLE;
          end else begin
            step_d  = step_q + 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          sel_d    = SEL_STATUS;
          rd_n_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = T_STROBE;
          state_d  = ST_READ;
        end
      end
      ST_READ: begin
        if (tmr_zero) begin
          rd_n_d = 1'b1;
          if ((din & BYTE_OUT_MASK) != 8'h00) begin
            step_d  = step_q + 1'b1;
            state_d = ST_FETCH;
          end else if (pc_zero) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            pc_dec   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = T_GAP;
            state_d  = ST_GAP;
          end
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      dout_q  <= '0;
      sel_q   <= SEL_STATUS;
      wr_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      sel_q   <= sel_d;
      wr_n_q  <= wr_n_d;
      rd_n_q  <= rd_n_d;
      err_q   <= err_d;
    end
  end

  assign busy    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done    = (state_q == ST_DONE);
  assign error   = err_q;
  assign reg_sel = sel_q;
  assign rd_n    = rd_n_q;
  assign wr_n    = wr_n_q;
  assign dout    = dout_q;
  assign dout_oe = ~wr_n_q;

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(!rd_n_q && !wr_n_q)); // R11
  AST_READ_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_n_q |-> (sel_q == SEL_STATUS)); // R6
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!wr_n_q && $past(!wr_n_q)) |-> ($stable(dout_q) && $stable(sel_q))); // R8
  AST_NO_WRITE_WHILE_POLL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_GAP || state_q == ST_READ) |-> wr_n_q); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done); // R9
  AST_ERR_RISES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(err_q) |-> done); // R10
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && start) |=> ($stable(op_q) && $stable(addr_q))); // R2

endmodule

// File: tb/bus_cmd_sequencer_bench.sv
module bus_cmd_sequencer_bench;

  localparam int STROBE_W   = 4;
  localparam int POLL_GAP   = 6;
  localparam int SETTLE_CYC = 200;
  localparam int POLL_LIMIT = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] opcode;
  logic [4:0] dev_addr;
  logic [7:0] din;
  logic       busy, done, error, rd_n, wr_n, dout_oe;
  logic [2:0] reg_sel;
  logic [7:0] dout;

  always #10 clk = ~clk;

  bus_cmd_sequencer #(
    .STROBE_W(STROBE_W), .POLL_GAP(POLL_GAP),
    .SETTLE_CYC(SETTLE_CYC), .POLL_LIMIT(POLL_LIMIT)
  ) u_bus_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .dev_addr(dev_addr), .din(din), .busy(busy), .done(done),
    .error(error), .reg_sel(reg_sel), .rd_n(rd_n), .wr_n(wr_n),
    .dout(dout), .dout_oe(dout_oe)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int bo_delay   = 0;
  int polls_seen = 0;
  int reads      = 0;
  int wr_len = 0, rd_len = 0, wr_rise = 0;
  bit pending_cmd = 0;
  logic       prev_wr = 1'b1, prev_rd = 1'b1;
  logic [2:0] wsel = '0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  // chip model: not-ready replies clear only bit 4; idle bus reads all ones
  always_comb din = rd_n ? 8'hFF : ((polls_seen >= bo_delay) ? 8'h10 : 8'hEF);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] sel, input logic [7:0] val, input string tag);
    exp_q.push_back({sel, val});
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [10:0] e;
    string t;
    cyc++;
    if (rst_n) begin
      if (dout_oe !== ~wr_n) chk(0, "R11", "dout_oe vs wr_n", dout_oe, ~wr_n);
      if (!rd_n && !wr_n)    chk(0, "R11", "both strobes low", 0, 1);
      if (prev_wr && !wr_n) begin
        if (pending_cmd)
          chk(reads == bo_delay + 1, "R7", "status reads before next write", reads, bo_delay + 1);
        pending_cmd = 0;
        if (exp_q.size() == 0) chk(0, "R2", "unexpected write", {reg_sel, dout}, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({reg_sel, dout} == e, t, "R6 select/byte of write", {reg_sel, dout}, e);
        end
        wsel = reg_sel; wr_len = 1; polls_seen = 0; reads = 0;
      end else if (!wr_n) wr_len++;
      if (!prev_wr && wr_n) begin
        chk(wr_len == STROBE_W, "R8", "write strobe width", wr_len, STROBE_W);
        wr_rise = cyc;
        if (wsel == 3'd7) pending_cmd = 1;
      end
      if (prev_rd && !rd_n) begin
        if (reads == 0) chk(cyc - wr_rise == POLL_GAP, "R7", "first poll delay", cyc - wr_rise, POLL_GAP);
        chk(reg_sel == 3'd0, "R6", "read select", reg_sel, 0);
        rd_len = 1;
      end else if (!rd_n) rd_len++;
      if (!prev_rd && rd_n) begin
        chk(rd_len == STROBE_W, "R8", "read strobe width", rd_len, STROBE_W);
        reads++; polls_seen++;
      end
    end
    prev_wr = wr_n;
    prev_rd = rd_n;
  end

  task automatic pulse_start(input logic [2:0] op, input logic [4:0] a);
    @(negedge clk);
    start = 1'b1; opcode = op; dev_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_seq(input logic [2:0] op, input logic [4:0] a, input bit timeout);
    logic [7:0] lb, cb;
    lb = 8'h20 + {3'b000, a};
    cb = (op == 3'd1) ? 8'h04 : (op == 3'd2) ? 8'h01 : 8'h08;
    if (op == 3'd0) begin
      push(3, 8'h0C, "R3"); push(7, 8'h3F, "R3");
      if (!timeout) begin
        push(7, 8'h5F, "R3"); push(7, 8'h14, "R3"); push(3, 8'h0B, "R3");
      end
    end else if (op == 3'd4) begin
      push(3, 8'h90, "R5"); push(3, 8'h0C, "R5"); push(7, 8'h3F, "R5");
      push(3, 8'h8A, "R5"); push(7, lb, "R5"); push(3, 8'h0B, "R5");
    end else begin
      push(3, 8'h0C, "R4"); push(7, 8'h3F, "R4");
      if (!timeout) begin
        push(3, 8'h8A, "R4"); push(7, lb, "R4"); push(7, cb, "R4"); push(3, 8'h0B, "R4");
      end
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [4:0] a, input int delay,
                         input bit timeout, input bit intrude);
    expect_seq(op, a, timeout);
    bo_delay = delay;
    pulse_start(op, a);
    #1;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(error == 1'b0, "R10", "error cleared by start", error, 0);
    if (intrude) begin
      repeat (15) @(negedge clk);
      pulse_start(3'd0, 5'd1);
    end
    do begin @(negedge clk); #1; end while (!done);
    chk(busy == 1'b0, "R9", "busy low at done", busy, 0);
    chk(error == timeout, "R10", "error at done", error, timeout);
    if (timeout)
      chk(reads == POLL_LIMIT, "R10", "reads before abort", reads, POLL_LIMIT);
    else
      chk(cyc - wr_rise == SETTLE_CYC, "R9", "settle after standby", cyc - wr_rise, SETTLE_CYC);
    chk(exp_q.size() == 0, "R3", "writes left unseen", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
    pending_cmd = 0;
    @(negedge clk); #1;
    chk(done == 1'b0, "R9", "done single cycle", done, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = '0; dev_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk(busy == 0 && done == 0 && error == 0, "R1", "status after reset", {busy, done, error}, 0);
    chk(rd_n == 1 && wr_n == 1 && dout_oe == 0, "R1", "strobes after reset", {rd_n, wr_n, dout_oe}, 3'b110);

    run_cmd(3'd0, 5'd0,  0, 0, 0);   // R3 clear all
    run_cmd(3'd1, 5'd5,  2, 0, 0);   // R4 selected clear
    run_cmd(3'd2, 5'd31, 0, 0, 0);   // R4 go-to-local, top address
    run_cmd(3'd3, 5'd0,  3, 0, 0);   // R4 trigger, address 0
    run_cmd(3'd4, 5'd12, 1, 0, 1);   // R5 remote enable, R2 start while busy

    // R2: reserved opcode is ignored
    pulse_start(3'd6, 5'd9);
    repeat (20) @(negedge clk);
    #1;
    chk(busy == 0 && wr_n == 1 && rd_n == 1, "R2", "reserved opcode ignored", {busy, wr_n, rd_n}, 3'b011);

    // R10: byte-out never appears
    run_cmd(3'd1, 5'd3, 1000, 1, 0);
    repeat (30) @(negedge clk);
    #1;
    chk(error == 1 && wr_n == 1 && busy == 0, "R10", "error held, port quiet", {error, wr_n, busy}, 3'b110);
    run_cmd(3'd0, 5'd7, 1, 0, 0);    // R10 error cleared on next start

    finish_run();
  end

endmodule